// File: doc/BRIEF.md
# Power-on Output Enable Sequencer

This block owns the output enables of a video decoder's pins from the moment power is applied until software has configured the device. While the asynchronous power-on reset input is low, every output the block governs is released to high impedance. After reset is removed, the block keeps all pins released for a programmable settling delay. It then runs a short internal synchronous reset interval. Only after that does it turn on the control group, which is the pixel clock output and the serial data line.

The data group is the pixel bus, the real-time control output and the two real-time status outputs. It stays released until the serial control bus slave reports, with a one-cycle pulse, that one complete configuration write has arrived. A configuration pulse that comes before the control group is active is discarded. A phase code lets the rest of the chip follow the sequence. Pulling the power-on reset low again at any moment starts the whole sequence over.

All delays are cycle counts set by parameters. The parameters are checked during elaboration.

Top module: `povs_top`

## Requirements
- R1: While `por_n_i` is low, every bit of `ctl_oe_o` and `data_oe_o` is 0 (high impedance) and `phase_o` reads 0. This takes effect asynchronously, without waiting for a clock edge.
- R2: After `por_n_i` rises, the phase stays at reset for `SYNC_STAGES` rising edges. It then shows delay (code 1) for exactly `DLY_CYCLES` cycles, and both groups stay at 0 throughout.
- R3: The delay phase is followed by the sync-reset phase (code 2), which lasts exactly `SRST_CYCLES` cycles with both groups at 0.
- R4: When sync-reset ends, the phase becomes wait-for-config (code 3): every bit of `ctl_oe_o` is 1 and every bit of `data_oe_o` stays 0.
- R5: If `cfg_done_i` is 1 at a rising edge in the wait-for-config phase, then from that edge on the phase is running (code 4) and every bit of `data_oe_o` is 1.
- R6: A `cfg_done_i` pulse seen in the reset, delay or sync-reset phase is discarded. The phase still reaches wait-for-config with `data_oe_o` all 0.
- R7: The running phase is held until `por_n_i` goes low, and further `cfg_done_i` pulses do not change it.
- R8: Taking `por_n_i` low in any phase, including mid-delay and wait-for-config, restarts the full sequence from R2.
- R9: `phase_o` encodes reset=0, delay=1, sync-reset=2, wait-for-config=3, running=4.
- R10: All bits within one enable group always carry the same value, and the data group is never on while the control group is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| cfg_done_i | input | 1 | One-cycle pulse when a complete configuration write has arrived |
| ctl_oe_o | output | CTL_W | Enables for the pixel clock output and serial data line, 1 = driven |
| data_oe_o | output | DATA_W | Enables for the pixel bus, real-time control and two status pins, 1 = driven |
| phase_o | output | 3 | Current phase code (see R9) |

## Verification
A behavioural model counts edges since reset release and is compared with the outputs on every cycle. The first pattern is a clean power-up with one configuration pulse. It shows that the delay and sync-reset windows have exactly the right length and that the two groups are enabled in order. In the second pattern, configuration pulses land in the delay and sync-reset windows and must be discarded, which separates a design that samples the strobe only in the waiting phase from one that remembers early pulses. In the third, reset is asserted in the middle of the delay, in the wait phase and in the running phase. The fourth holds the strobe high across the wait-phase entry, showing the cycle on which the first legal sample is taken.

// File: rtl/povs_pkg.sv
package povs_pkg;

   typedef enum logic [2:0] {
      PH_RESET = 3'd0,
      PH_DELAY = 3'd1,
      PH_SRST  = 3'd2,
      PH_WAIT  = 3'd3,
      PH_RUN   = 3'd4
   } phase_e;

endpackage

// File: rtl/povs_rst_sync.sv
module povs_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic arst_n_i,
   output logic srst_n_o
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk_i or negedge arst_n_i) begin
            if (!arst_n_i) chain_q <= 1'b0;
            else           chain_q <= 1'b1;
         end
      end else begin : g_chain
         always_ff @(posedge clk_i or negedge arst_n_i) begin
            if (!arst_n_i) chain_q <= '0;
            else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
         end
      end
   endgenerate

   assign srst_n_o = chain_q[STAGES-1];

   // R1
   always_ff @(posedge clk_i) begin
      if (!arst_n_i) begin
         sync_low_in_reset_chk: assert (srst_n_o == 1'b0)
            else $error("synchronised reset high while power-on reset low");
      end
   end

endmodule

// File: rtl/povs_timer.sv
module povs_timer #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_n_i,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)          cnt_q <= '0;
      else if (load_i)       cnt_q <= load_val_i;
      else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
   end

   assign zero_o = (cnt_q == '0);

   // R2
   property tmr_hold_zero_p;
      @(posedge clk_i) disable iff (!rst_n_i)
         (zero_o && !load_i) |=> zero_o;
   endproperty
   tmr_hold_zero_chk: assert property (tmr_hold_zero_p)
      else $error("timer left zero without a load");

   // R3
   property tmr_step_p;
      @(posedge clk_i) disable iff (!rst_n_i)
         (!zero_o && !load_i) |=> (cnt_q == $past(cnt_q) - W'(1));
   endproperty
   tmr_step_chk: assert property (tmr_step_p)
      else $error("timer did not step by one");

endmodule

// File: rtl/povs_oe_fan.sv
module povs_oe_fan #(
   parameter int W = 1
) (
   input  logic         en_i,
   output logic [W-1:0] oe_o
);

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign oe_o[i] = en_i;
      end
   endgenerate

endmodule

// File: rtl/povs_top.sv
module povs_top
   import povs_pkg::*;
#(
   parameter int DLY_CYCLES  = 540000,
   parameter int SRST_CYCLES = 16,
   parameter int SYNC_STAGES = 2,
   parameter int CTL_W       = 2,
   parameter int DATA_W      = 11
) (
   input  logic              clk_i,
   input  logic              por_n_i,
   input  logic              cfg_done_i,
   output logic [CTL_W-1:0]  ctl_oe_o,
   output logic [DATA_W-1:0] data_oe_o,
   output logic [2:0]        phase_o
);

   localparam int MAX_CNT = (DLY_CYCLES > SRST_CYCLES) ? DLY_CYCLES : SRST_CYCLES;
   localparam int CNT_W   = $clog2(MAX_CNT + 1);

   generate
      if (DLY_CYCLES < 1) begin : g_bad_dly
         $error("DLY_CYCLES must be at least 1");
      end
      if (SRST_CYCLES < 1) begin : g_bad_srst
         $error("SRST_CYCLES must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (CTL_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("enable group widths must be at least 1");
      end
   endgenerate

   logic             srst_n;
   phase_e           phase_q, phase_d;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_zero;
   logic             ctl_en;
   logic             data_en;

   povs_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i    (clk_i),
      .arst_n_i (por_n_i),
      .srst_n_o (srst_n)
   );

   povs_timer #(.W(CNT_W)) u_timer (
      .clk_i      (clk_i),
      .rst_n_i    (srst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .zero_o     (tmr_zero)
   );

   always_comb begin
      phase_d  = phase_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (phase_q)
         PH_RESET: begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(DLY_CYCLES - 1);
            phase_d  = PH_DELAY;
         end
         PH_DELAY: begin
            if (tmr_zero) begin
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(SRST_CYCLES - 1);
               phase_d  = PH_SRST;
            end
         end
         PH_SRST: begin
            if (tmr_zero) phase_d = PH_WAIT;
         end
         PH_WAIT: begin
            if (cfg_done_i) phase_d = PH_RUN;
         end
         PH_RUN:  phase_d = PH_RUN;
         default: phase_d = PH_RESET;
      endcase
   end

   always_ff @(posedge clk_i or negedge srst_n) begin
      if (!srst_n) phase_q <= PH_RESET;
      else         phase_q <= phase_d;
   end

   assign ctl_en  = (phase_q == PH_WAIT) || (phase_q == PH_RUN);
   assign data_en = (phase_q == PH_RUN);
   assign phase_o = phase_q;

   povs_oe_fan #(.W(CTL_W)) u_ctl_fan (
      .en_i (ctl_en),
      .oe_o (ctl_oe_o)
   );

   povs_oe_fan #(.W(DATA_W)) u_data_fan (
      .en_i (data_en),
      .oe_o (data_oe_o)
   );

   // R4
   property ctl_rise_from_srst_p;
      @(posedge clk_i) disable iff (!srst_n)
         $rose(ctl_en) |-> ($past(phase_q) == PH_SRST);
   endproperty
   ctl_rise_from_srst_chk: assert property (ctl_rise_from_srst_p)
      else $error("control group enabled outside sync-reset exit");

   // R5
   property data_rise_needs_cfg_p;
      @(posedge clk_i) disable iff (!srst_n)
         $rose(data_en) |-> ($past(cfg_done_i) && $past(phase_q) == PH_WAIT);
   endproperty
   data_rise_needs_cfg_chk: assert property (data_rise_needs_cfg_p)
      else $error("data group enabled without a configuration strobe");

   // R10
   property data_needs_ctl_p;
      @(posedge clk_i) disable iff (!srst_n)
         (data_oe_o != '0) |-> (ctl_oe_o == '1);
   endproperty
   data_needs_ctl_chk: assert property (data_needs_ctl_p)
      else $error("data group on while control group off");

   // R7
   property run_sticky_p;
      @(posedge clk_i) disable iff (!srst_n)
         (phase_q == PH_RUN) |=> (phase_q == PH_RUN);
   endproperty
   run_sticky_chk: assert property (run_sticky_p)
      else $error("running phase left without reset");

   // R3
   property srst_hold_p;
      @(posedge clk_i) disable iff (!srst_n)
         (phase_q == PH_SRST && !tmr_zero) |=> (phase_q == PH_SRST);
   endproperty
   srst_hold_chk: assert property (srst_hold_p)
      else $error("sync-reset phase ended early");

endmodule

// File: tb/povs_top_tb_top.sv
module povs_top_tb_top;

   localparam int CLK_T  = 10;
   localparam int N_SYNC = 2;
   localparam int N_DLY  = 5;
   localparam int N_SRST = 3;
   localparam int CW     = 2;
   localparam int DW     = 11;

   logic          clk = 1'b0;
   logic          por_n;
   logic          cfg;
   logic [CW-1:0] ctl_oe;
   logic [DW-1:0] data_oe;
   logic [2:0]    phase;

   int n_run  = 0;
   int n_fail = 0;
   int cycles = 0;

   int m_edges = 0;
   int m_phase = 0;
   bit m_run   = 0;

   always #(CLK_T/2) clk = ~clk;

   povs_top #(
      .DLY_CYCLES  (N_DLY),
      .SRST_CYCLES (N_SRST),
      .SYNC_STAGES (N_SYNC),
      .CTL_W       (CW),
      .DATA_W      (DW)
   ) dut_i (
      .clk_i      (clk),
      .por_n_i    (por_n),
      .cfg_done_i (cfg),
      .ctl_oe_o   (ctl_oe),
      .data_oe_o  (data_oe),
      .phase_o    (phase)
   );

   task automatic chk(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
      end
   endtask

   function automatic string tag_of(int ph);
      case (ph)
         0:       return "R1/R2 reset";
         1:       return "R2 delay";
         2:       return "R3 sync-reset";
         3:       return "R4 wait";
         default: return "R5 run";
      endcase
   endfunction

   // reference model: phase from edges counted since release
   always @(posedge clk) begin
      int prev;
      cycles++;
      if (!por_n) begin
         m_edges = 0;
         m_run   = 0;
         m_phase = 0;
      end else begin
         prev = m_phase;
         m_edges++;
         if (prev == 3 && cfg) m_run = 1;
         if (m_run)                                m_phase = 4;
         else if (m_edges <= N_SYNC)               m_phase = 0;
         else if (m_edges <= N_SYNC + N_DLY)       m_phase = 1;
         else if (m_edges <= N_SYNC+N_DLY+N_SRST)  m_phase = 2;
         else                                      m_phase = 3;
      end
      #(CLK_T/4);
      chk({"R9 phase code, ", tag_of(m_phase)}, int'(phase), m_phase);
      chk({"ctl group, ", tag_of(m_phase)}, int'(ctl_oe),
          (m_phase >= 3) ? int'({CW{1'b1}}) : 0);
      chk({"data group, ", tag_of(m_phase)}, int'(data_oe),
          (m_phase == 4) ? int'({DW{1'b1}}) : 0);
      // R10 uniform groups
      chk("R10 ctl uniform", int'(ctl_oe == '0 || ctl_oe == '1), 1);
      chk("R10 data uniform", int'(data_oe == '0 || data_oe == '1), 1);
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      wait (cycles > 20000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
      finish_run();
   end

   initial begin
      por_n = 1'b0;
      cfg   = 1'b0;
      cyc(3);
      #1;
      chk("R1 reset ctl off", int'(ctl_oe), 0);
      chk("R1 reset data off", int'(data_oe), 0);
      chk("R1 reset phase", int'(phase), 0);

      // clean power-up
      @(negedge clk); por_n = 1'b1;
      cyc(N_SYNC + N_DLY + N_SRST + 3);
      chk("R4 wait reached", int'(phase), 3);
      cfg = 1'b1; cyc(1); cfg = 1'b0;
      cyc(4);
      chk("R5 data on", int'(data_oe), int'({DW{1'b1}}));
      cfg = 1'b1; cyc(1); cfg = 1'b0;
      cyc(3);
      chk("R7 run sticky", int'(phase), 4);

      // asynchronous reset from running
      por_n = 1'b0;
      #1;
      chk("R1 async ctl off", int'(ctl_oe), 0);
      chk("R1 async data off", int'(data_oe), 0);
      cyc(2);

      // early strobes in delay and sync-reset
      por_n = 1'b1;
      cyc(4);
      cfg = 1'b1; cyc(1); cfg = 1'b0;
      cyc(3);
      cfg = 1'b1; cyc(1); cfg = 1'b0;
      cyc(4);
      chk("R6 early strobe ignored phase", int'(phase), 3);
      chk("R6 early strobe ignored data", int'(data_oe), 0);

      // reset in wait, then in mid-delay
      por_n = 1'b0; cyc(2);
      por_n = 1'b1; cyc(5);
      chk("R8 mid-delay before reset", int'(phase), 1);
      por_n = 1'b0; cyc(1);
      por_n = 1'b1; cyc(2);
      chk("R8 restart in reset phase", int'(phase), 0);
      cyc(1);
      chk("R8 restart enters delay", int'(phase), 1);

      // strobe held high across wait entry
      cyc(N_DLY + 1);
      cfg = 1'b1; cyc(6); cfg = 1'b0;
      cyc(3);
      chk("R8 restart completes to run", int'(phase), 4);
      chk("R5 held strobe enables data", int'(data_oe), int'({DW{1'b1}}));
      cyc(2);
      finish_run();
   end

endmodule